// File: doc/BRIEF.md
# DRAM power-up initialization sequencer

This block sits on the controller side of an external DDR3-style memory. It owns the memory's active-low reset, its clock-enable, a run flag for the memory clock and the command bus, from power-on until the memory can take normal traffic. After a synchronous `start` pulse, it counts cycles of its own system clock to meet a chain of minimum waits:
- Reset is held, and then clock-enable is kept low for a short setup before reset is let go.
- The block waits out the memory's internal initialization.
- The memory clock is run for a stability window.
- A NOP is presented.
- Clock-enable is raised and then held through the DLL-lock and ZQ-init intervals.

After that, `init_done` rises. From then on, commands from the upstream controller pass to the memory through one register.

Each wait is given as a time in nanoseconds or as a cycle count, and the block converts it into clock cycles using the clock period parameter, rounding up. One down-counter times every step. A new `start` pulse at any moment begins the whole sequence again.

Top module: `dram_init_seq`

## Requirements
- R1: After `rst`, and until the first `start`, `mem_reset_n`, `cke`, `ck_run` and `init_done` are 0 and `cmd_out` is NOP, whatever `cmd_in` does.
- R2: The clock edge that samples `start` drives `mem_reset_n` low, and it stays low for at least RESET_CYC = ceil(T_RESET_NS·1000/CLK_PERIOD_PS) cycles.
- R3: `mem_reset_n` stays low for a further CKE_SETUP_CYC = ceil(T_CKE_SETUP_NS·1000/CLK_PERIOD_PS) cycles while `cke` is already low, then rises with `cke` still low.
- R4: `cke` stays low for RELEASE_CYC = ceil(T_RELEASE_NS·1000/CLK_PERIOD_PS) cycles after reset release. `ck_run` then rises, and it stays high for CKSTAB_CYC = max(ceil(T_CKSTAB_NS·1000/CLK_PERIOD_PS), CKSTAB_MIN_CYC) cycles before the NOP step.
- R5: During NOP_CYC cycles just before `cke` rises, `cmd_out` is NOP. `cke` rises only while `mem_reset_n` and `ck_run` are high.
- R6: Once `cke` has risen, it stays high with no gap until `init_done`. `init_done` rises 1 + max(DLLK_CYC, ZQINIT_CYC) cycles after the rise of `cke`.
- R7: `init_done` is high only after the whole sequence has finished. It then stays high, together with `cke`, `mem_reset_n` and `ck_run`, until the next `start` or `rst`.
- R8: `cmd_out` is the 4-bit code {cs_n, ras_n, cas_n, we_n}. The NOP value is 4'b0111. While `init_done` is 0, `cmd_out` is forced to NOP. Once `init_done` is 1, `cmd_out` equals `cmd_in` as sampled at the previous clock edge.
- R9: A `start` pulse in any state, including partway through the sequence or after `init_done`, restarts from the reset-hold step with the same timing as R2 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Synchronous pulse: begin or restart initialization |
| cmd_in | input | 4 | Upstream command {cs_n, ras_n, cas_n, we_n} |
| mem_reset_n | output | 1 | Active-low memory reset |
| cke | output | 1 | Memory clock-enable |
| ck_run | output | 1 | Memory clock running flag |
| cmd_out | output | 4 | Command to the memory {cs_n, ras_n, cas_n, we_n} |
| init_done | output | 1 | Initialization complete |

## Verification
Every output is registered from the next state. As a result, the edge that samples `start` is cycle 0 of the sequence, and each output change lands at a fixed number of cycles after it:
- `mem_reset_n` rises at RESET_CYC+CKE_SETUP_CYC.
- `ck_run` rises RELEASE_CYC cycles later.
- `cke` rises after a further CKSTAB_CYC+NOP_CYC cycles.
- `init_done` rises 1+max(DLLK_CYC, ZQINIT_CYC) cycles after that.

`cmd_out` shows `cmd_in` one edge late once the block is done. The bench holds a count of cycles since the last `start`, advanced at each rising edge. It derives every expected output from thresholds on that count, and it compares all outputs at the falling edge after each rising edge. Restarts are placed partway through the sequence and after completion, so that the count falls back to zero at a known edge.

// File: rtl/dram_init_pkg.sv
package dram_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RESET_HOLD,
    ST_CKE_LOW_SETUP,
    ST_RELEASE_WAIT,
    ST_CLK_STABLE,
    ST_NOP_ISSUE,
    ST_CKE_HIGH,
    ST_INIT_WAIT,
    ST_DONE
  } init_state_e;

  localparam int unsigned CMD_W   = 4;
  localparam logic [CMD_W-1:0] CMD_NOP = 4'b0111;

  // round a time in nanoseconds up to whole clock cycles
  function automatic int unsigned ns_to_cyc(longint unsigned t_ns, longint unsigned per_ps);
    longint unsigned q;
    q = (t_ns * 64'd1000 + per_ps - 64'd1) / per_ps;
    return int'(q);
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/init_timer.sv
module init_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/init_fsm.sv
module init_fsm
  import dram_init_pkg::*;
#(
  parameter int unsigned CNT_W         = 32,
  parameter int unsigned RESET_CYC     = 1,
  parameter int unsigned CKE_SETUP_CYC = 1,
  parameter int unsigned RELEASE_CYC   = 1,
  parameter int unsigned CKSTAB_CYC    = 1,
  parameter int unsigned NOP_CYC       = 1,
  parameter int unsigned INIT_CYC      = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tmr_zero,
  output init_state_e      state,
  output init_state_e      next_state,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  function automatic init_state_e succ(init_state_e s);
    case (s)
      ST_RESET_HOLD:    return ST_CKE_LOW_SETUP;
      ST_CKE_LOW_SETUP: return ST_RELEASE_WAIT;
      ST_RELEASE_WAIT:  return ST_CLK_STABLE;
      ST_CLK_STABLE:    return ST_NOP_ISSUE;
      ST_NOP_ISSUE:     return ST_CKE_HIGH;
      ST_CKE_HIGH:      return ST_INIT_WAIT;
      default:          return ST_DONE;
    endcase
  endfunction

  // dwell length of a state minus one (value loaded into the timer)
  function automatic logic [CNT_W-1:0] dwell_m1(init_state_e s);
    case (s)
      ST_RESET_HOLD:    return CNT_W'(RESET_CYC - 1);
      ST_CKE_LOW_SETUP: return CNT_W'(CKE_SETUP_CYC - 1);
      ST_RELEASE_WAIT:  return CNT_W'(RELEASE_CYC - 1);
      ST_CLK_STABLE:    return CNT_W'(CKSTAB_CYC - 1);
      ST_NOP_ISSUE:     return CNT_W'(NOP_CYC - 1);
      ST_INIT_WAIT:     return CNT_W'(INIT_CYC - 1);
      default:          return '0;
    endcase
  endfunction

  always_comb begin
    next_state = state;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    if (start) begin
      next_state = ST_RESET_HOLD;
      tmr_load   = 1'b1;
      tmr_val    = dwell_m1(ST_RESET_HOLD);
    end else if (state != ST_IDLE && state != ST_DONE && tmr_zero) begin
      next_state = succ(state);
      tmr_load   = 1'b1;
      tmr_val    = dwell_m1(succ(state));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
    end else begin
      state <= next_state;
    end
  end

endmodule

// File: rtl/init_outputs.sv
module init_outputs
  import dram_init_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  init_state_e      next_state,
  input  logic [CMD_W-1:0] cmd_in,
  output logic             mem_reset_n,
  output logic             cke,
  output logic             ck_run,
  output logic [CMD_W-1:0] cmd_out,
  output logic             init_done
);

  logic rel_n, cke_n, run_n, done_n;

  always_comb begin
    rel_n  = 1'b0;
    cke_n  = 1'b0;
    run_n  = 1'b0;
    done_n = 1'b0;
    case (next_state)
      ST_RELEASE_WAIT: rel_n = 1'b1;
      ST_CLK_STABLE, ST_NOP_ISSUE: begin
        rel_n = 1'b1;
        run_n = 1'b1;
      end
      ST_CKE_HIGH, ST_INIT_WAIT: begin
        rel_n = 1'b1;
        run_n = 1'b1;
        cke_n = 1'b1;
      end
      ST_DONE: begin
        rel_n  = 1'b1;
        run_n  = 1'b1;
        cke_n  = 1'b1;
        done_n = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_reset_n <= 1'b0;
      cke         <= 1'b0;
      ck_run      <= 1'b0;
      init_done   <= 1'b0;
      cmd_out     <= CMD_NOP;
    end else begin
      mem_reset_n <= rel_n;
      cke         <= cke_n;
      ck_run      <= run_n;
      init_done   <= done_n;
      cmd_out     <= done_n ? cmd_in : CMD_NOP;
    end
  end

endmodule

// File: rtl/dram_init_seq.sv
module dram_init_seq
  import dram_init_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS  = 8000,
  parameter int unsigned T_RESET_NS     = 200000,
  parameter int unsigned T_CKE_SETUP_NS = 10,
  parameter int unsigned T_RELEASE_NS   = 500000,
  parameter int unsigned T_CKSTAB_NS    = 10,
  parameter int unsigned CKSTAB_MIN_CYC = 5,
  parameter int unsigned NOP_CYC        = 1,
  parameter int unsigned DLLK_CYC       = 512,
  parameter int unsigned ZQINIT_CYC     = 512,
  parameter int unsigned CNT_W          = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [3:0] cmd_in,
  output logic       mem_reset_n,
  output logic       cke,
  output logic       ck_run,
  output logic [3:0] cmd_out,
  output logic       init_done
);

  localparam int unsigned RESET_CYC     = umax(1, ns_to_cyc(T_RESET_NS, CLK_PERIOD_PS));
  localparam int unsigned CKE_SETUP_CYC = umax(1, ns_to_cyc(T_CKE_SETUP_NS, CLK_PERIOD_PS));
  localparam int unsigned RELEASE_CYC   = umax(1, ns_to_cyc(T_RELEASE_NS, CLK_PERIOD_PS));
  localparam int unsigned CKSTAB_CYC    = umax(umax(1, CKSTAB_MIN_CYC),
                                               ns_to_cyc(T_CKSTAB_NS, CLK_PERIOD_PS));
  localparam int unsigned NOP_LEN       = umax(1, NOP_CYC);
  localparam int unsigned INIT_CYC      = umax(1, umax(DLLK_CYC, ZQINIT_CYC));

  init_state_e      state, next_state;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  init_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  init_fsm #(
    .CNT_W         (CNT_W),
    .RESET_CYC     (RESET_CYC),
    .CKE_SETUP_CYC (CKE_SETUP_CYC),
    .RELEASE_CYC   (RELEASE_CYC),
    .CKSTAB_CYC    (CKSTAB_CYC),
    .NOP_CYC       (NOP_LEN),
    .INIT_CYC      (INIT_CYC)
  ) i_fsm (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .tmr_zero   (tmr_zero),
    .state      (state),
    .next_state (next_state),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val)
  );

  init_outputs i_outs (
    .clk         (clk),
    .rst         (rst),
    .next_state  (next_state),
    .cmd_in      (cmd_in),
    .mem_reset_n (mem_reset_n),
    .cke         (cke),
    .ck_run      (ck_run),
    .cmd_out     (cmd_out),
    .init_done   (init_done)
  );

endmodule

// File: rtl/dram_init_seq_chk.sv
module dram_init_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [3:0] cmd_in,
  input logic       mem_reset_n,
  input logic       cke,
  input logic       ck_run,
  input logic [3:0] cmd_out,
  input logic       init_done
);

  localparam logic [3:0] NOP = 4'b0111;

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (!mem_reset_n && !ck_run && !start) |=> (!cke && !init_done));

  assert_release_cke_low_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_reset_n) |-> (!cke && $past(!cke)));

  assert_cke_after_nop_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> (mem_reset_n && ck_run && $past(cmd_out) == NOP));

  assert_cke_held_R6: assert property (@(posedge clk) disable iff (rst)
    (cke && !init_done && !start) |=> cke);

  assert_done_levels_R7: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cke && mem_reset_n && ck_run));

  assert_nop_forced_R8: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> (cmd_out == NOP));

  assert_pass_through_R8: assert property (@(posedge clk) disable iff (rst)
    (init_done && $past(init_done)) |-> (cmd_out == $past(cmd_in)));

  assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> (!mem_reset_n && !cke && !ck_run && !init_done));

endmodule

bind dram_init_seq dram_init_seq_chk i_chk (.*);

// File: tb/test_dram_init_seq.sv
module test_dram_init_seq;

  localparam int PER_PS  = 8000;
  localparam int TRST    = 200;
  localparam int TSETUP  = 10;
  localparam int TREL    = 400;
  localparam int TSTAB   = 10;
  localparam int STABMIN = 5;
  localparam int NOPN    = 2;
  localparam int DLLK    = 20;
  localparam int ZQI     = 30;

  // expected step boundaries, in cycles since the start edge
  localparam int A  = (TRST * 1000 + PER_PS - 1) / PER_PS;
  localparam int B  = (TSETUP * 1000 + PER_PS - 1) / PER_PS;
  localparam int C  = (TREL * 1000 + PER_PS - 1) / PER_PS;
  localparam int D0 = (TSTAB * 1000 + PER_PS - 1) / PER_PS;
  localparam int D  = (D0 > STABMIN) ? D0 : STABMIN;
  localparam int I  = (DLLK > ZQI) ? DLLK : ZQI;
  localparam int T_REL  = A + B;
  localparam int T_RUN  = T_REL + C;
  localparam int T_CKE  = T_RUN + D + NOPN;
  localparam int T_DONE = T_CKE + 1 + I;
  localparam logic [3:0] NOP = 4'b0111;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [3:0] cmd_in = 4'h0;
  logic mem_reset_n, cke, ck_run, init_done;
  logic [3:0] cmd_out;

  always #4 clk = ~clk;

  dram_init_seq #(
    .CLK_PERIOD_PS(PER_PS), .T_RESET_NS(TRST), .T_CKE_SETUP_NS(TSETUP),
    .T_RELEASE_NS(TREL), .T_CKSTAB_NS(TSTAB), .CKSTAB_MIN_CYC(STABMIN),
    .NOP_CYC(NOPN), .DLLK_CYC(DLLK), .ZQINIT_CYC(ZQI), .CNT_W(32)
  ) i_dram_init_seq (
    .clk(clk), .rst(rst), .start(start), .cmd_in(cmd_in),
    .mem_reset_n(mem_reset_n), .cke(cke), .ck_run(ck_run),
    .cmd_out(cmd_out), .init_done(init_done)
  );

  int checks = 0;
  int errors = 0;
  int t = -1;
  bit restarted = 1'b0;
  logic [3:0] exp_cmd = NOP;
  int cyc = 0;
  bit finished = 1'b0;

  // reference: count of cycles since the last sampled start
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      t = -1;
      exp_cmd = NOP;
    end else begin
      if (start) begin
        if (t >= 0) restarted = 1'b1;
        t = 0;
      end else if (t >= 0 && t < 1000000) begin
        t++;
      end
      exp_cmd = (t >= T_DONE) ? cmd_in : NOP;
    end
    if (cyc > 20000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk1(string tag, string nm, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s t=%0d actual %b expected %b", tag, nm, t, act, exp);
    end
  endtask

  task automatic compare();
    string tg;
    logic [3:0] ec;
    ec = exp_cmd;
    if (t < 0) begin
      tg = "R1";
      chk1(tg, "mem_reset_n", mem_reset_n, 1'b0);
      chk1(tg, "cke", cke, 1'b0);
      chk1(tg, "ck_run", ck_run, 1'b0);
      chk1(tg, "init_done", init_done, 1'b0);
    end else begin
      tg = restarted ? "R9" : ((t < A) ? "R2" : "R3");
      chk1(tg, "mem_reset_n", mem_reset_n, t >= T_REL);
      tg = restarted ? "R9" : "R4";
      chk1(tg, "ck_run", ck_run, t >= T_RUN);
      tg = restarted ? "R9" : ((t < T_CKE) ? "R5" : "R6");
      chk1(tg, "cke", cke, t >= T_CKE);
      tg = restarted ? "R9" : "R7";
      chk1(tg, "init_done", init_done, t >= T_DONE);
    end
    checks++;
    if (cmd_out !== ec) begin
      errors++;
      $display("FAIL R8 cmd_out t=%0d actual %h expected %h", t, cmd_out, ec);
    end
  endtask

  logic [7:0] lfsr = 8'hA5;

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      cmd_in = lfsr[3:0];
      start = 1'b0;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    compare();
    start = 1'b1;
  endtask

  initial begin
    step(3);
    @(negedge clk);
    rst = 1'b0;
    step(12);                 // R1: idle with changing commands
    pulse_start();            // R2..R8 first full sequence
    step(T_DONE + 20);
    pulse_start();            // R9 restart after done
    step(T_RUN + 3);
    pulse_start();            // R9 restart partway
    step(T_DONE + 15);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule